// File: doc/BRIEF.md
# I2C Memory Target Read Engine

This block is an I2C target that behaves like a byte-addressed serial memory. It oversamples the clock and data lines with the system clock and recognises Start, repeated Start and Stop. It checks the 7-bit device address in the first byte of a transfer, takes in a two-byte word address, and pulls the data line low through an open-drain enable to acknowledge bytes and to send read data. The storage is an internal byte array of parameterized depth, 4096 or 8192 bytes.

One address counter serves every access. A write of the word address loads it, and every byte read or written advances it by one. It wraps from the top of the array to zero. A read that begins right after the device address uses the counter as it stands. A read that follows a word-address write and a repeated Start returns the byte at the address just sent. Each acknowledge from the controller after a data byte fetches the next byte. A simple single-byte write is included, so that software can set up both memory contents and the counter.

Top module: `serial_mem_target`

## Requirements
- R1: A falling data line while the clock is high is a Start, and a rising data line while the clock is high is a Stop. After reset and after a Stop the block leaves the data line released.
- R2: The direction bit is the least significant bit of the device address byte, with 1 for read and 0 for write. If the upper seven bits differ from the DEV_ADDR parameter, the block leaves that byte unacknowledged and drives nothing until the next Start.
- R3: Random read: Start, the device address with direction 0, the two word-address bytes, a repeated Start and then the device address with direction 1. The block returns the byte stored at that word address.
- R4: The block acknowledges, by pulling the data line low in the ninth clock, each of these: a matching device address byte, both word-address bytes, and each write data byte. A write data byte is stored at the counter location.
- R5: A read that starts right after the device address, with no word address, returns the byte at the current counter value.
- R6: After any byte at location n is read or written, the counter holds n+1.
- R7: From the last location of the array the counter wraps to location 0, for both writes and reads, including reads that stream without a break.
- R8: During a read, a low data line (ACK) in the ninth clock makes the block send the next byte. A high data line (NACK) ends the read, and the block keeps the data line released through any further clocks until a Start or Stop.
- R9: The block changes the data line only while the clock is low. Read data goes out most significant bit first and is stable through each high clock phase.
- R10: The word address is sent high byte first. Address bits above the array width are ignored, so with 4096 bytes only the low 12 bits count.
- R11: A Start or Stop at any bit position abandons the current byte and returns to address decoding or idle. The counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the I2C clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | I2C clock line as seen at the pin |
| sdaIn | input | 1 | I2C data line as seen at the pin |
| sdaOe | output | 1 | When 1 the pad pulls the data line low, otherwise the line is released |

## Verification
A wrong bit or byte count inside the block shows at the ports within one byte time. The acknowledge appears in the wrong clock, or read data comes out shifted, and the bench flags that on the very next byte it checks. A counter that is off, or one that moves after an aborted or ignored transfer, only shows when the next current-address read returns a byte other than the one the bench model expects. So every abort, mismatch and NACK case is followed at once by such a read. Wrap errors show on the first byte past the top location, in both a streaming read and a current-address read that follows a write to the last location.

// File: rtl/smt_pkg.sv
package smt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_AHI,
    ST_ACK_AHI,
    ST_ALO,
    ST_ACK_ALO,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_RACK,
    ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftIn;    // capture sdaBit into the receive shifter
    logic sdaBit;     // sampled data line value
    logic latchHi;    // keep received byte as word-address high byte
    logic loadCnt;    // load counter from the assembled word address
    logic storeByte;  // write received byte at counter, advance counter
    logic fetchByte;  // read byte at counter into transmit shifter, advance
    logic shiftOut;   // move the next transmit bit to the front
  } dpStrobe_t;

endpackage

// File: rtl/smt_ctrl.sv
module smt_ctrl
  import smt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  stb,
  output logic       sdaOe
);

  localparam int LAST_SYNC = SYNC_STAGES - 1;

  logic [LAST_SYNC:0] sclPipe;
  logic [LAST_SYNC:0] sdaPipe;
  logic               sclPrev;
  logic               sdaPrev;
  logic               sclNow;
  logic               sdaNow;

  assign sclNow = sclPipe[LAST_SYNC];
  assign sdaNow = sdaPipe[LAST_SYNC];

  logic sclRise;
  logic sclFall;
  logic startEv;
  logic stopEv;

  assign sclRise = sclNow && !sclPrev;
  assign sclFall = !sclNow && sclPrev;
  assign startEv = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopEv  = sclNow && sclPrev && !sdaPrev && sdaNow;

  busState_t  state;
  logic [3:0] bitCnt;
  logic       rwBit;
  logic       hostAck;
  logic       byteFull;
  logic       rxState;

  assign byteFull = (bitCnt == 4'd8);
  assign rxState  = (state == ST_DEV) || (state == ST_AHI) ||
                    (state == ST_ALO) || (state == ST_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[LAST_SYNC-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST_SYNC-1:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rwBit   <= 1'b0;
      hostAck <= 1'b0;
    end else if (stopEv) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (startEv) begin
      state  <= ST_DEV;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_DEV: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && byteFull) begin
            bitCnt <= '0;
            if (rxByte[7:1] == DEV_ADDR) begin
              state <= ST_ACK_DEV;
              rwBit <= rxByte[0];
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_AHI, ST_ALO, ST_WR: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && byteFull) begin
            bitCnt <= '0;
            state  <= (state == ST_AHI) ? ST_ACK_AHI :
                      (state == ST_ALO) ? ST_ACK_ALO : ST_ACK_WR;
          end
        end
        ST_ACK_DEV: if (sclFall) state <= rwBit ? ST_RD : ST_AHI;
        ST_ACK_AHI: if (sclFall) state <= ST_ALO;
        ST_ACK_ALO: if (sclFall) state <= ST_WR;
        ST_ACK_WR:  if (sclFall) state <= ST_WR;
        ST_RD: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              state  <= ST_RACK;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) hostAck <= !sdaNow;
          else if (sclFall) state <= hostAck ? ST_RD : ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  // Strobes: Start/Stop need the clock high for two samples, so they never
  // coincide with a clock edge and need no gating here.
  always_comb begin
    stb           = '0;
    stb.sdaBit    = sdaNow;
    stb.shiftIn   = sclRise && rxState;
    stb.latchHi   = sclFall && byteFull && (state == ST_AHI);
    stb.loadCnt   = sclFall && byteFull && (state == ST_ALO);
    stb.storeByte = sclFall && byteFull && (state == ST_WR);
    stb.fetchByte = sclFall && (((state == ST_ACK_DEV) && rwBit) ||
                                ((state == ST_RACK) && hostAck));
    stb.shiftOut  = sclFall && (state == ST_RD) && (bitCnt != 4'd7);
  end

  always_comb begin
    sdaOe = (state == ST_ACK_DEV) || (state == ST_ACK_AHI) ||
            (state == ST_ACK_ALO) || (state == ST_ACK_WR)  ||
            ((state == ST_RD) && !txBit);
  end

  // R9: the pull-down only moves while the sampled clock is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclNow);

  // R1: a Stop always leads back to idle with the line released
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (state == ST_IDLE) && !sdaOe);

  // R2: a device address that does not match is never acknowledged
  p_mismatch_nack_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && sclFall && byteFull && rxByte[7:1] != DEV_ADDR)
      |=> !sdaOe);

  // R8: after a NACK the block stays off the line
  p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclFall && !hostAck) |=> !sdaOe && $stable(bitCnt));

endmodule

// File: rtl/smt_dp.sv
module smt_dp
  import smt_pkg::*;
#(
  parameter int MEM_BYTES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  output logic [7:0] rxByte,
  output logic       txBit
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam logic [AW-1:0] TOP_ADDR = AW'(MEM_BYTES - 1);

  logic [7:0]    rxShift;
  logic [7:0]    txShift;
  logic [7:0]    hiReg;
  logic [AW-1:0] cnt;
  logic [15:0]   wordAddr;
  logic [7:0]    memArr [MEM_BYTES];

  assign wordAddr = {hiReg, rxShift};
  assign rxByte   = rxShift;
  assign txBit    = txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      hiReg   <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], stb.sdaBit};
      if (stb.latchHi) hiReg <= rxShift;
    end
  end

  // Counter: loaded by a word address, advanced by every data byte; the
  // array depth is a power of two so the add wraps at the top location.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.loadCnt) begin
      cnt <= wordAddr[AW-1:0];
    end else if (stb.storeByte || stb.fetchByte) begin
      cnt <= cnt + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (stb.fetchByte) begin
      txShift <= memArr[cnt];
    end else if (stb.shiftOut) begin
      txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte) memArr[cnt] <= rxShift;
  end

  // R11: the counter only moves on a load or a data byte
  p_cnt_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadCnt || stb.storeByte || stb.fetchByte) |=> $stable(cnt));

  // R7: the top location is followed by location 0
  p_cnt_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == TOP_ADDR && !stb.loadCnt && (stb.storeByte || stb.fetchByte))
      |=> cnt == '0);

  // R6: at most one counter action per cycle
  p_one_action_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadCnt, stb.storeByte, stb.fetchByte}));

endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
  import smt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_BYTES   = 4096,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  dpStrobe_t  stb;
  logic [7:0] rxByte;
  logic       txBit;

  smt_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .rxByte(rxByte),
    .txBit (txBit),
    .stb   (stb),
    .sdaOe (sdaOe)
  );

  smt_dp #(
    .MEM_BYTES(MEM_BYTES)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rxByte(rxByte),
    .txBit (txBit)
  );

endmodule

// File: tb/serial_mem_target_tb.sv
module serial_mem_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int D          = 4096;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe;
  logic sdaLine;

  assign sdaLine = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_mem_target dut_i (
    .clk  (clk),
    .rstN (rstN),
    .sclIn(sclDrv),
    .sdaIn(sdaLine),
    .sdaOe(sdaOe)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] model [D];
  int cntM = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; tick(H);
    sclDrv = 1'b1; tick(H);
    sdaDrv = 1'b0; tick(H);
    sclDrv = 1'b0; tick(H);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; tick(H);
    sclDrv = 1'b1; tick(H);
    sdaDrv = 1'b1; tick(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; tick(H);
      sclDrv = 1'b1; tick(H);
      sclDrv = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaDrv = 1'b1; tick(H);
    sclDrv = 1'b1; tick(H / 2);
    acked = !sdaLine; tick(H / 2);
    sclDrv = 1'b0;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b, output bit steady);
    logic s0, s1;
    steady = 1'b1;
    b = '0;
    sdaDrv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(H);
      sclDrv = 1'b1; tick(1);
      s0 = sdaLine; tick(H - 2);
      s1 = sdaLine;
      if (s0 != s1) steady = 1'b0;
      b = {b[6:0], s0};
      tick(1);
      sclDrv = 1'b0;
    end
    sdaDrv = ackIt ? 1'b0 : 1'b1; tick(H);
    sclDrv = 1'b1; tick(H);
    sclDrv = 1'b0;
    sdaDrv = 1'b1;
  endtask

  task automatic readBytes(input int n, input string req);
    logic [7:0] b;
    bit st;
    for (int i = 0; i < n; i++) begin
      recvByte(i < n - 1, b, st);
      chk(b == model[cntM], req, "read byte", b, model[cntM]);
      chk(st, "R9", "bit stable while clock high", st, 1);
      cntM = (cntM + 1) % D;
    end
  endtask

  task automatic sendAddr(input logic [15:0] word);
    bit a1, a2, a3;
    busStart();
    sendByte(DEV_W, a1);
    sendByte(word[15:8], a2);
    sendByte(word[7:0], a3);
    chk(a1 && a2 && a3, "R4", "ack of write address bytes", {a1, a2, a3}, 7);
  endtask

  task automatic doWrite(input logic [15:0] word, input logic [7:0] data);
    bit a4;
    sendAddr(word);
    sendByte(data, a4);
    busStop();
    chk(a4, "R4", "ack of write data", a4, 1);
    model[word % D] = data;
    cntM = (word + 1) % D;
  endtask

  task automatic doRandRead(input logic [15:0] word, input int n, input string req);
    bit a;
    sendAddr(word);
    busStart();
    sendByte(DEV_R, a);
    chk(a, "R4", "ack of read device address", a, 1);
    cntM = word % D;
    readBytes(n, req);
    busStop();
  endtask

  task automatic doCurRead(input int n, input string req);
    bit a;
    busStart();
    sendByte(DEV_R, a);
    chk(a, "R5", "ack of current read address", a, 1);
    readBytes(n, req);
    busStop();
  endtask

  initial begin
    bit a, bad;
    logic [7:0] b;
    bit st;
    logic [15:0] w;
    logic [7:0] d;
    void'($urandom(32'd2024));
    tick(5);
    rstN = 1'b1;
    tick(5);
    chk(sdaOe == 1'b0 && sdaLine == 1'b1, "R1", "released after reset", sdaOe, 0);

    // Fill both ends of the array with single-byte writes
    for (int i = 0; i < 8; i++) doWrite(16'(i), 8'(8'h30 + i));
    for (int i = D - 8; i < D; i++) doWrite(16'(i), 8'(8'hC0 ^ i));

    // Last write hit the top location: current read wraps to 0 (R7, R5)
    doCurRead(3, "R7");
    // Random read then current read continue from n+1 (R3, R6)
    doRandRead(16'd3, 1, "R3");
    doCurRead(2, "R6");
    // Streaming read across the top boundary (R8, R7)
    doRandRead(16'(D - 4), 8, "R8");
    // Upper address bits ignored (R10)
    doRandRead(16'hF000 | 16'(D - 2), 1, "R10");
    doCurRead(1, "R6");

    // Wrong device address: no ack, next byte ignored, counter kept (R2)
    busStart();
    sendByte(8'hA2, a);
    chk(!a, "R2", "mismatch not acked", a, 0);
    sendByte(8'h00, a);
    chk(!a, "R2", "ignored byte not acked", a, 0);
    busStop();
    doCurRead(1, "R2");

    // NACK ends the read; the line stays released (R8)
    sendAddr(16'(D - 8));
    busStart();
    sendByte(DEV_R, a);
    cntM = D - 8;
    recvByte(1'b0, b, st);
    chk(b == model[cntM], "R8", "single byte before nack", b, model[cntM]);
    cntM = cntM + 1;
    bad = 1'b0;
    for (int k = 0; k < 9; k++) begin
      tick(H);
      sclDrv = 1'b1; tick(H / 2);
      if (!sdaLine) bad = 1'b1;
      tick(H / 2);
      sclDrv = 1'b0;
    end
    chk(!bad, "R8", "released after nack", bad, 0);
    busStop();
    doCurRead(1, "R6");

    // Stop in the middle of the high address byte (R11)
    busStart();
    sendByte(DEV_W, a);
    sendBits(8'h05, 4);
    busStop();
    doCurRead(2, "R11");

    // Repeated Start in the middle of the low address byte (R1, R11)
    busStart();
    sendByte(DEV_W, a);
    sendByte(8'h00, a);
    sendBits(8'h05, 3);
    busStart();
    sendByte(DEV_R, a);
    chk(a, "R1", "restart decoded as new address", a, 1);
    readBytes(1, "R11");
    busStop();

    // Random write/read-back with junk upper address bits (R3, R10)
    for (int i = 0; i < 10; i++) begin
      w = 16'($urandom) & 16'hF000 | 16'($urandom_range(D - 1));
      d = 8'($urandom);
      doWrite(w, d);
      w = (16'($urandom) & 16'hF000) | (w & 16'(D - 1));
      doRandRead(w, 1, "R3");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule